// File: doc/BRIEF.md
# Frame Sync Flywheel with Alignment-Change Detection

This block keeps the bit and time-slot time base for one port of a time-slotted serial bus. One strobe input marks the first bit of a frame. Each frame holds a configured number of slots, and each slot holds a fixed number of bits. On the first strobe it samples, the block locks its counters to that bit. From then on it free-runs: it counts bits within a slot and slots within a frame, and it wraps at the end of the frame without needing any further strobe.

A strobe that arrives anywhere other than the frame wrap point is a change of frame alignment. The same condition is raised if no strobe has arrived one whole frame after start-up. The block then realigns its counters to the new strobe and raises an alignment-error flag on both the receive and the transmit outputs. The flag stays up until two frame wraps have passed with no further bad strobe. Entering the condition fires a one-cycle interrupt for each direction whose enable is set. Every rising strobe seen while the flag is up fires another such interrupt straight away.

The slot count and the sampling edge are captured once, on the first clock after reset. A sampled strobe reaches the counters with a fixed delay of two rising clock edges. On the edge where the counters reach slot 0 bit 0, frame_start_o pulses.

Top module: `frame_flywheel`

## Requirements
- R1: While reset is held, and until the first strobe is sampled, slot_idx_o and bit_idx_o are 0, and frame_start_o, both error flags and both interrupts are 0.
- R2: A strobe sampled high when the block is unlocked locks the flywheel. Two rising edges after the sampling edge, slot_idx_o=0, bit_idx_o=0 and frame_start_o=1.
- R3: Once locked, bit_idx_o counts 0..7 on each clock and slot_idx_o then steps. The frame lasts (slots_m1_i+1)*8 cycles, with slots_m1_i from 0 to 127, so 1 to 128 slots. At the wrap, frame_start_o pulses for one cycle and both indices return to 0, with no strobe needed.
- R4: A strobe sampled while the counters show the last bit of the last slot is expected. It causes no alignment error and no interrupt, and the frame timing does not change.
- R5: A strobe sampled at any other position while locked sets cofa_rx_o and cofa_tx_o two edges after the sampling edge. In that same cycle the counters restart at slot 0 bit 0 with frame_start_o=1.
- R6: If no strobe is sampled within (slots_m1_i+1)*8 cycles after the configuration is loaded, both error flags rise, so that cofa is 1 at the L+1-th falling edge after reset release.
- R7: After the last bad strobe or missing-strobe event, the error flags stay high for exactly two frames (2*(slots_m1_i+1)*8 cycles) and drop on the second wrap.
- R8: Entering the error condition fires a one-cycle pulse on irq_rx_o if rx_irq_en_i is 1, and on irq_tx_o if tx_irq_en_i is 1. A direction whose enable is 0 stays 0.
- R9: A rising strobe sampled while the flags are high fires another one-cycle interrupt in the same cycle that its effect appears. If that strobe is at the wrap point, the hold time is not extended.
- R10: slots_m1_i and fall_sel_i are captured on the first rising edge after reset release. Later changes have no effect until the next reset.
- R11: With fall_sel_i=1, the strobe is sampled on the falling clock edge. A pulse seen only at a falling edge then locks the flywheel, with frame_start_o appearing at the third falling edge after the rising edge that precedes the pulse. With fall_sel_i=0, the same pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strb_i | input | 1 | Frame strobe; high marks slot 0 bit 0 |
| fall_sel_i | input | 1 | 1: sample strobe on falling edge; 0: rising edge |
| slots_m1_i | input | 7 | Slots per frame minus one |
| rx_irq_en_i | input | 1 | Receive-direction interrupt enable |
| tx_irq_en_i | input | 1 | Transmit-direction interrupt enable |
| slot_idx_o | output | 7 | Current time slot |
| bit_idx_o | output | 3 | Current bit within the slot |
| frame_start_o | output | 1 | High on slot 0 bit 0 |
| cofa_rx_o | output | 1 | Alignment-error flag, receive direction |
| cofa_tx_o | output | 1 | Alignment-error flag, transmit direction |
| irq_rx_o | output | 1 | Receive alignment interrupt pulse |
| irq_tx_o | output | 1 | Transmit alignment interrupt pulse |

## Verification
A slipped bit or slot counter shows up within one frame. frame_start_o then pulses a cycle early or late, and an expected strobe is wrongly reported as an alignment error. A wrong hold count shows as error flags that fall before, or stay up after, exactly two frames from the last event. A lost lock or a stale sample register shows within a few cycles, as indices that stay at zero after a strobe. Interrupt logic that is wrongly gated shows in the single cycle after entry into the error condition, or after a rising strobe during it, on the direction outputs.

// File: rtl/fsf_pkg.sv
`timescale 1ns/1ps
package fsf_pkg;
  localparam int DEF_MAX_SLOTS   = 128;
  localparam int DEF_SLOT_BITS   = 8;
  localparam int DEF_HOLD_FRAMES = 2;
  localparam int N_DIR           = 2;

  typedef struct packed {
    logic evt;   // alignment change or missing first strobe
    logic roll;  // natural frame wrap while locked
  } fw_evt_t;
endpackage

// File: rtl/fsf_strobe_sampler.sv
`timescale 1ns/1ps
module fsf_strobe_sampler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strb_i,
  input  logic fall_sel_i,
  output logic smp_o,
  output logic rise_o
);
  logic neg_q, smp_q, prev_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) neg_q <= 1'b0;
    else         neg_q <= strb_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      smp_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      smp_q  <= fall_sel_i ? neg_q : strb_i;
      prev_q <= smp_q;
    end
  end

  assign smp_o  = smp_q;
  assign rise_o = smp_q & ~prev_q;

  assert_rise_single_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/fsf_flywheel.sv
`timescale 1ns/1ps
module fsf_flywheel
  import fsf_pkg::*;
#(
  parameter int MAX_SLOTS = DEF_MAX_SLOTS,
  parameter int SLOT_BITS = DEF_SLOT_BITS,
  localparam int SLOT_W   = $clog2(MAX_SLOTS),
  localparam int BIT_W    = $clog2(SLOT_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [SLOT_W-1:0] slots_m1_i,
  input  logic              smp_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic              fs_o,
  output fw_evt_t           ev_o
);
  localparam int LEN_W = $clog2(MAX_SLOTS * SLOT_BITS + 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(SLOT_BITS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [BIT_W-1:0]  bit_q;
  logic [LEN_W-1:0]  tmo_q, len_m1;
  logic              fs_q, locked_q, wrap, misalign, miss;

  assign len_m1 = LEN_W'((int'(slots_m1_i) + 1) * SLOT_BITS - 1);

  always_comb begin
    wrap      = (bit_q == BIT_LAST) && (slot_q == slots_m1_i);
    misalign  = run_i && locked_q && smp_i && !wrap;
    miss      = run_i && !locked_q && !smp_i && (tmo_q == len_m1);
    ev_o.evt  = misalign | miss;
    ev_o.roll = run_i && locked_q && wrap;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      bit_q    <= '0;
      fs_q     <= 1'b0;
      locked_q <= 1'b0;
      tmo_q    <= '0;
    end else if (run_i) begin
      if (smp_i) begin
        locked_q <= 1'b1;
        slot_q   <= '0;
        bit_q    <= '0;
        fs_q     <= 1'b1;
        tmo_q    <= '0;
      end else if (!locked_q) begin
        fs_q  <= 1'b0;
        tmo_q <= miss ? '0 : tmo_q + 1'b1;
      end else begin
        fs_q <= wrap;
        if (bit_q == BIT_LAST) begin
          bit_q  <= '0;
          slot_q <= (slot_q == slots_m1_i) ? '0 : slot_q + 1'b1;
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end

  assign slot_o = slot_q;
  assign bit_o  = bit_q;
  assign fs_o   = fs_q;

  assert_fs_at_origin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> (bit_q == '0 && slot_q == '0));
  assert_slot_in_frame_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_q <= slots_m1_i);
  assert_lock_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> locked_q);
  assert_idle_until_lock_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked_q |-> (bit_q == '0 && slot_q == '0));
endmodule

// File: rtl/fsf_cofa_ctrl.sv
`timescale 1ns/1ps
module fsf_cofa_ctrl
  import fsf_pkg::*;
#(
  parameter int HOLD_FRAMES = DEF_HOLD_FRAMES,
  parameter int NDIR        = N_DIR
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  fw_evt_t         ev_i,
  input  logic            rise_i,
  input  logic [NDIR-1:0] irq_en_i,
  output logic [NDIR-1:0] cofa_o,
  output logic [NDIR-1:0] irq_o
);
  localparam int CNT_W = $clog2(HOLD_FRAMES + 1);

  logic             cofa_q, irq_trig;
  logic [CNT_W-1:0] clean_q;
  logic [NDIR-1:0]  irq_q;

  assign irq_trig = (ev_i.evt & ~cofa_q) | (cofa_q & rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cofa_q  <= 1'b0;
      clean_q <= '0;
      irq_q   <= '0;
    end else begin
      irq_q <= {NDIR{irq_trig}} & irq_en_i;
      if (ev_i.evt) begin
        cofa_q  <= 1'b1;
        clean_q <= '0;
      end else if (cofa_q && ev_i.roll) begin
        if (clean_q == CNT_W'(HOLD_FRAMES - 1)) begin
          cofa_q  <= 1'b0;
          clean_q <= '0;
        end else begin
          clean_q <= clean_q + 1'b1;
        end
      end
    end
  end

  assign cofa_o = {NDIR{cofa_q}};
  assign irq_o  = irq_q;

  assert_evt_sets_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.evt |=> cofa_q);
  assert_clear_on_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cofa_q) |-> ($past(ev_i.roll) && !$past(ev_i.evt)));

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    assert_irq_has_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_q[d] |-> (cofa_q || $past(cofa_q)));
    assert_irq_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_q[d] && !rise_i && !ev_i.evt) |=> !irq_q[d]);
  end
endmodule

// File: rtl/frame_flywheel.sv
`timescale 1ns/1ps
module frame_flywheel
  import fsf_pkg::*;
#(
  parameter int MAX_SLOTS   = DEF_MAX_SLOTS,
  parameter int SLOT_BITS   = DEF_SLOT_BITS,
  parameter int HOLD_FRAMES = DEF_HOLD_FRAMES,
  localparam int SLOT_W     = $clog2(MAX_SLOTS),
  localparam int BIT_W      = $clog2(SLOT_BITS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strb_i,
  input  logic              fall_sel_i,
  input  logic [SLOT_W-1:0] slots_m1_i,
  input  logic              rx_irq_en_i,
  input  logic              tx_irq_en_i,
  output logic [SLOT_W-1:0] slot_idx_o,
  output logic [BIT_W-1:0]  bit_idx_o,
  output logic              frame_start_o,
  output logic              cofa_rx_o,
  output logic              cofa_tx_o,
  output logic              irq_rx_o,
  output logic              irq_tx_o
);
  logic              cfg_ok_q, fall_q;
  logic [SLOT_W-1:0] slots_q;
  logic              smp, rise;
  fw_evt_t           ev;
  logic [N_DIR-1:0]  cofa, irq;

  // configuration captured once per reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_ok_q <= 1'b0;
      fall_q   <= 1'b0;
      slots_q  <= '0;
    end else if (!cfg_ok_q) begin
      cfg_ok_q <= 1'b1;
      fall_q   <= fall_sel_i;
      slots_q  <= slots_m1_i;
    end
  end

  fsf_strobe_sampler u_smp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .strb_i     (strb_i),
    .fall_sel_i (fall_q),
    .smp_o      (smp),
    .rise_o     (rise)
  );

  fsf_flywheel #(
    .MAX_SLOTS (MAX_SLOTS),
    .SLOT_BITS (SLOT_BITS)
  ) u_fw (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (cfg_ok_q),
    .slots_m1_i (slots_q),
    .smp_i      (smp),
    .slot_o     (slot_idx_o),
    .bit_o      (bit_idx_o),
    .fs_o       (frame_start_o),
    .ev_o       (ev)
  );

  fsf_cofa_ctrl #(
    .HOLD_FRAMES (HOLD_FRAMES),
    .NDIR        (N_DIR)
  ) u_cofa (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ev_i     (ev),
    .rise_i   (rise & cfg_ok_q),
    .irq_en_i ({tx_irq_en_i, rx_irq_en_i}),
    .cofa_o   (cofa),
    .irq_o    (irq)
  );

  assign cofa_rx_o = cofa[0];
  assign cofa_tx_o = cofa[1];
  assign irq_rx_o  = irq[0];
  assign irq_tx_o  = irq[1];

  assert_cfg_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_ok_q |=> ($stable(slots_q) && $stable(fall_q)));
  assert_dirs_agree_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cofa_rx_o == cofa_tx_o);
endmodule

// File: tb/frame_flywheel_bench.sv
`timescale 1ns/1ps
module frame_flywheel_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strb = 1'b0, fall_sel = 1'b0, rx_en = 1'b1, tx_en = 1'b1;
  logic [6:0] slots_m1 = '0;
  logic [6:0] slot_idx;
  logic [2:0] bit_idx;
  logic       fs, cofa_rx, cofa_tx, irq_rx, irq_tx;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frame_flywheel u_frame_flywheel (
    .clk_i(clk), .rst_ni(rst_ni), .strb_i(strb), .fall_sel_i(fall_sel),
    .slots_m1_i(slots_m1), .rx_irq_en_i(rx_en), .tx_irq_en_i(tx_en),
    .slot_idx_o(slot_idx), .bit_idx_o(bit_idx), .frame_start_o(fs),
    .cofa_rx_o(cofa_rx), .cofa_tx_o(cofa_tx), .irq_rx_o(irq_rx), .irq_tx_o(irq_tx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input int sm1, input bit fall, input bit rxe, input bit txe);
    @(negedge clk);
    rst_ni = 1'b0; strb = 1'b0;
    slots_m1 = 7'(sm1); fall_sel = fall; rx_en = rxe; tx_en = txe;
    step(2);
    rst_ni = 1'b1;
  endtask

  task automatic pulse();
    strb = 1'b1;
    @(negedge clk);
    strb = 1'b0;
  endtask

  task automatic lock();
    step(3); pulse(); step(1);
  endtask

  task automatic t_reset();
    @(negedge clk); rst_ni = 1'b0; step(1);
    chk("R1 slot in reset", slot_idx, 0);
    chk("R1 bit in reset", bit_idx, 0);
    chk("R1 fs in reset", fs, 0);
    chk("R1 flags in reset", {cofa_rx, cofa_tx, irq_rx, irq_tx}, 0);
    do_reset(2, 0, 1, 1); step(3);
    chk("R1 idle before strobe", {slot_idx, bit_idx, fs}, 0);
  endtask

  task automatic t_count();
    do_reset(2, 0, 1, 1); lock();
    chk("R2 lock fs", fs, 1);
    chk("R2 lock origin", {slot_idx, bit_idx}, 0);
    step(9);
    chk("R3 slot mid", slot_idx, 1); chk("R3 bit mid", bit_idx, 1); chk("R3 fs mid", fs, 0);
    step(15);
    chk("R3 wrap fs", fs, 1); chk("R3 wrap origin", {slot_idx, bit_idx}, 0);
    step(23);
    chk("R3 last slot", slot_idx, 2); chk("R3 last bit", bit_idx, 7);
    step(1);
    chk("R3 free-run fs", fs, 1); chk("R3 no error", cofa_rx, 0);
  endtask

  task automatic t_aligned();
    do_reset(1, 0, 1, 1); lock(); step(14); pulse(); step(1);
    chk("R4 fs at wrap", fs, 1); chk("R4 origin", {slot_idx, bit_idx}, 0);
    chk("R4 no flag", {cofa_rx, cofa_tx}, 0); chk("R4 no irq", {irq_rx, irq_tx}, 0);
    step(16);
    chk("R4 timing kept", fs, 1);
  endtask

  task automatic t_misalign();
    do_reset(1, 0, 1, 1); lock(); step(5); pulse(); step(1);
    chk("R5 realign fs", fs, 1); chk("R5 realign origin", {slot_idx, bit_idx}, 0);
    chk("R5 flag rx", cofa_rx, 1); chk("R5 flag tx", cofa_tx, 1);
    chk("R8 irq rx", irq_rx, 1); chk("R8 irq tx", irq_tx, 1);
    step(1);
    chk("R8 irq one cycle", {irq_rx, irq_tx}, 0); chk("R7 held", cofa_rx, 1);
    step(30);
    chk("R7 still held", {cofa_rx, cofa_tx}, 3);
    step(1);
    chk("R7 released", {cofa_rx, cofa_tx}, 0); chk("R7 release at wrap", fs, 1);
  endtask

  task automatic t_rise();
    do_reset(1, 0, 1, 1); lock(); step(5); pulse(); step(1);
    step(14); pulse(); step(1);
    chk("R9 irq rx on rise", irq_rx, 1); chk("R9 irq tx on rise", irq_tx, 1);
    chk("R9 flag stays", cofa_rx, 1); chk("R9 aligned fs", fs, 1);
    step(1);
    chk("R9 irq one cycle", {irq_rx, irq_tx}, 0);
    step(14);
    chk("R9 hold not extended (held)", cofa_rx, 1);
    step(1);
    chk("R9 hold not extended (clear)", cofa_rx, 0);
  endtask

  task automatic t_mask();
    do_reset(0, 0, 1, 0); lock(); step(7);
    chk("R3 one-slot bit7", bit_idx, 7); chk("R3 one-slot slot0", slot_idx, 0);
    step(1);
    chk("R3 one-slot wrap", fs, 1);
    step(3); pulse(); step(1);
    chk("R8 rx enabled", irq_rx, 1); chk("R8 tx masked", irq_tx, 0);
    chk("R8 tx flag unmasked", cofa_tx, 1);
  endtask

  task automatic t_missing();
    do_reset(0, 0, 1, 1); step(8);
    chk("R6 not yet", cofa_rx, 0);
    step(1);
    chk("R6 missing sync flag", {cofa_rx, cofa_tx}, 3); chk("R6 irq", irq_rx, 1);
    step(1); pulse(); step(1);
    chk("R9 lock during flag irq", irq_rx, 1); chk("R2 lock fs", fs, 1);
    step(15);
    chk("R7 held after lock", cofa_rx, 1);
    step(1);
    chk("R7 clear after two wraps", cofa_rx, 0);
  endtask

  task automatic t_cfg();
    do_reset(1, 0, 1, 1); lock(); step(3);
    slots_m1 = 7'd5;
    step(13);
    chk("R10 old length kept", fs, 1);
    step(16);
    chk("R10 old length kept again", fs, 1);
    do_reset(127, 0, 1, 1); lock(); step(1023);
    chk("R3 max slot", slot_idx, 127); chk("R3 max bit", bit_idx, 7); chk("R3 max fs", fs, 0);
    step(1);
    chk("R3 max wrap", fs, 1); chk("R10 new length used", slot_idx, 0);
  endtask

  task automatic t_edge();
    do_reset(127, 1, 1, 1); step(3);
    @(posedge clk); #1 strb = 1'b1; #2 strb = 1'b0;
    @(negedge clk);
    chk("R11 fall mode not yet", fs, 0);
    @(negedge clk);
    chk("R11 fall mode lock fs", fs, 1);
    chk("R11 fall mode origin", {slot_idx, bit_idx}, 0);
    step(3);
    chk("R11 fall mode counting", bit_idx, 3);
    do_reset(127, 0, 1, 1); step(3);
    @(posedge clk); #1 strb = 1'b1; #2 strb = 1'b0;
    @(negedge clk); @(negedge clk);
    chk("R11 rise mode ignores pulse fs", fs, 0);
    step(5);
    chk("R11 rise mode stays unlocked", {slot_idx, bit_idx}, 0);
  endtask

  initial begin
    step(2);
    t_reset();
    t_count();
    t_aligned();
    t_misalign();
    t_rise();
    t_mask();
    t_missing();
    t_cfg();
    t_edge();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule